// File: doc/BRIEF.md
# Return Stack and Next-PC Unit

This unit decides where a nibble-addressed processor fetches next and keeps the hardware stack of return addresses. Each cycle in which `valid_i` is high it takes one already-decoded control-flow kind. It also takes the address of the current instruction, the instruction length, a raw offset field, an absolute target, the result of a condition test evaluated elsewhere, and the low 20 bits of a data register. On the next clock edge it produces the next program counter. Where the kind asks for it, the same edge also gives a value to write back to the data register, a carry-flag write and a pulse that sets the module-missing status bit.

The stack is eight entries of 20 bits. Entry 0 is the top. Calls and explicit pushes shift a new entry in at the top, and returns and explicit pops shift the stack up. An empty stack therefore reads as address 0, and a push onto a full stack loses the oldest entry.

A conditional branch whose 8-bit offset is zero acts as a conditional return. Relative targets are formed as `pc_i` plus the sign-extended offset, so the integrator passes the address the offset is measured from in `pc_i`. All outputs are registered and appear one cycle after the strobe.

Top module: `retstack_branch_unit`

## Requirements
- R1: After reset `pc_o` is 0, `rdat_we_o`, `cy_we_o` and `xm_set_o` are low, and the stack is empty, so the first pop returns 0.
- R2: Kind 0 (sequential), and kind 1 (conditional) with `cond_i` low, set `pc_o` to `pc_i + len_i` and leave the stack unchanged, including when the offset is zero.
- R3: Kind 1 with `cond_i` high and a non-zero `ofs_i[7:0]` sets `pc_o` to `pc_i` plus `ofs_i[7:0]` sign-extended, covering -128 to +127.
- R4: Kind 1 with `cond_i` high and `ofs_i[7:0]` zero acts as a return: `pc_o` becomes the top entry and the stack pops.
- R5: Kind 2 adds the sign-extended `ofs_i[11:0]` to `pc_i` (-2048..+2047). Kind 3 adds the sign-extended `ofs_i[15:0]` (-32768..+32767). Upper offset bits not in the field have no effect.
- R6: Calls (kind 4 with a 12-bit offset, kind 5 with a 16-bit offset, kind 7 absolute to `tgt_i`) push `pc_i + len_i` and load the target.
- R7: Kind 6 loads `pc_o` with `tgt_i`.
- R8: Kind 10 (return) loads `pc_o` from the top entry and pops the stack.
- R9: Kind 11 returns and writes carry 0. Kind 12 returns and writes carry 1. Each pulses `cy_we_o` for one cycle with `cy_o` holding the value.
- R10: Kind 13 returns and pulses `xm_set_o` for one cycle. No other kind raises it.
- R11: Kind 8 loads `pc_o` from `reg_i`. Kind 9 loads `pc_o` from `reg_i` and returns `pc_i + len_i` on `rdat_o` with `rdat_we_o` high.
- R12: Kind 14 pushes `reg_i` and advances to `pc_i + len_i`. Kind 15 pops, returns the top entry on `rdat_o` with `rdat_we_o` high, and advances to `pc_i + len_i`.
- R13: A push onto eight live entries discards the oldest. A pop or return on an empty stack yields 0.
- R14: While `valid_i` is low, `pc_o` and the stack hold and no write pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Strobe: apply the presented kind this cycle |
| kind_i | input | 4 | Decoded control-flow kind, codes 0..15 |
| pc_i | input | 20 | Current instruction address / offset base |
| len_i | input | 4 | Instruction length in nibbles |
| ofs_i | input | 16 | Raw signed offset field |
| tgt_i | input | 20 | Absolute target address |
| cond_i | input | 1 | Condition result for kind 1 |
| reg_i | input | 20 | Low 20 bits of the data register |
| pc_o | output | 20 | Next program counter |
| rdat_o | output | 20 | Value to write into the data register |
| rdat_we_o | output | 1 | One-cycle write strobe for `rdat_o` |
| cy_we_o | output | 1 | One-cycle carry write strobe |
| cy_o | output | 1 | Carry value to write |
| xm_set_o | output | 1 | One-cycle pulse setting the module-missing bit |

## Verification
A call made while all eight entries are live pushes a new entry and drops the oldest on the same edge. The carry-setting and flag-setting returns also pop the stack and update a flag on one edge. The bench provokes the first case with nine pushes followed by nine pops, expecting the eight newest values in reverse order and then 0. It provokes the second with calls paired with the flag-setting returns, and checks the popped PC and the flag pulse in the same output cycle.

// File: rtl/retstack_branch_unit.sv
module retstack_branch_unit #(
  parameter int AW    = 20,
  parameter int DEPTH = 8,
  parameter int LW    = 4,
  parameter int OW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [3:0]    kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic [LW-1:0] len_i,
  input  logic [OW-1:0] ofs_i,
  input  logic [AW-1:0] tgt_i,
  input  logic          cond_i,
  input  logic [AW-1:0] reg_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] rdat_o,
  output logic          rdat_we_o,
  output logic          cy_we_o,
  output logic          cy_o,
  output logic          xm_set_o
);
  localparam logic [3:0] K_SEQ = 4'd0,  K_BCOND = 4'd1,  K_BRA12 = 4'd2,  K_BRA16 = 4'd3;
  localparam logic [3:0] K_BSR12 = 4'd4, K_BSR16 = 4'd5, K_JMPA = 4'd6,  K_JSRA = 4'd7;
  localparam logic [3:0] K_JREG = 4'd8, K_XPC = 4'd9,    K_RTN = 4'd10,  K_RTNCC = 4'd11;
  localparam logic [3:0] K_RTNSC = 4'd12, K_RTNXM = 4'd13, K_PUSH = 4'd14, K_POP = 4'd15;

  logic [AW-1:0] stk [DEPTH];

  wire [AW-1:0] top    = stk[0];
  wire [AW-1:0] seq_pc = pc_i + AW'(len_i);
  wire [AW-1:0] rel8   = pc_i + {{(AW-8){ofs_i[7]}}, ofs_i[7:0]};
  wire [AW-1:0] rel12  = pc_i + {{(AW-12){ofs_i[11]}}, ofs_i[11:0]};
  wire [AW-1:0] rel16  = pc_i + {{(AW-OW){ofs_i[OW-1]}}, ofs_i};
  wire          cret   = cond_i && (ofs_i[7:0] == 8'd0);

  logic          do_push, do_pop, r_we, c_we, c_val, xm;
  logic [AW-1:0] push_val, pc_nx, r_val;

  always_comb begin
    do_push  = 1'b0;
    do_pop   = 1'b0;
    push_val = seq_pc;
    pc_nx    = seq_pc;
    r_we     = 1'b0;
    r_val    = top;
    c_we     = 1'b0;
    c_val    = 1'b0;
    xm       = 1'b0;
    case (kind_i)
      K_BCOND: if (cret) begin pc_nx = top; do_pop = 1'b1; end
               else if (cond_i) pc_nx = rel8;
      K_BRA12: pc_nx = rel12;
      K_BRA16: pc_nx = rel16;
      K_BSR12: begin pc_nx = rel12; do_push = 1'b1; end
      K_BSR16: begin pc_nx = rel16; do_push = 1'b1; end
      K_JMPA:  pc_nx = tgt_i;
      K_JSRA:  begin pc_nx = tgt_i; do_push = 1'b1; end
      K_JREG:  pc_nx = reg_i;
      K_XPC:   begin pc_nx = reg_i; r_we = 1'b1; r_val = seq_pc; end
      K_RTN:   begin pc_nx = top; do_pop = 1'b1; end
      K_RTNCC: begin pc_nx = top; do_pop = 1'b1; c_we = 1'b1; end
      K_RTNSC: begin pc_nx = top; do_pop = 1'b1; c_we = 1'b1; c_val = 1'b1; end
      K_RTNXM: begin pc_nx = top; do_pop = 1'b1; xm = 1'b1; end
      K_PUSH:  begin do_push = 1'b1; push_val = reg_i; end
      K_POP:   begin do_pop = 1'b1; r_we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (valid_i) begin
      if (do_push) begin
        stk[0] <= push_val;
        for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
      end else if (do_pop) begin
        for (int i = 0; i < DEPTH-1; i++) stk[i] <= stk[i+1];
        stk[DEPTH-1] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o      <= '0;
      rdat_o    <= '0;
      rdat_we_o <= 1'b0;
      cy_we_o   <= 1'b0;
      cy_o      <= 1'b0;
      xm_set_o  <= 1'b0;
    end else begin
      rdat_we_o <= valid_i && r_we;
      cy_we_o   <= valid_i && c_we;
      xm_set_o  <= valid_i && xm;
      if (valid_i) begin
        pc_o <= pc_nx;
        if (r_we) rdat_o <= r_val;
        if (c_we) cy_o <= c_val;
      end
    end
  end

  // R2
  nt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && kind_i == K_BCOND && !cond_i |=> pc_o == $past(pc_i + AW'(len_i)) && stk[0] == $past(stk[0]));

  // R8
  ret_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && kind_i == K_RTN |=> pc_o == $past(stk[0]));

  // R9
  cy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cy_we_o |-> $past(valid_i) && ($past(kind_i) == K_RTNCC || $past(kind_i) == K_RTNSC));

  // R10
  xm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xm_set_o |-> $past(valid_i) && $past(kind_i) == K_RTNXM);

  // R12
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && kind_i == K_PUSH |=> stk[0] == $past(reg_i));

  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(pc_o) && !rdat_we_o && !cy_we_o && !xm_set_o);
endmodule

// File: tb/test_retstack_branch_unit.sv
module test_retstack_branch_unit;
  logic        clk = 1'b0, rst_n = 1'b0, valid_i = 1'b0, cond_i = 1'b0;
  logic [3:0]  kind_i = '0, len_i = '0;
  logic [19:0] pc_i = '0, tgt_i = '0, reg_i = '0;
  logic [15:0] ofs_i = '0;
  logic [19:0] pc_o, rdat_o;
  logic        rdat_we_o, cy_we_o, cy_o, xm_set_o;

  retstack_branch_unit i_retstack_branch_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i), .pc_i(pc_i),
    .len_i(len_i), .ofs_i(ofs_i), .tgt_i(tgt_i), .cond_i(cond_i), .reg_i(reg_i),
    .pc_o(pc_o), .rdat_o(rdat_o), .rdat_we_o(rdat_we_o), .cy_we_o(cy_we_o),
    .cy_o(cy_o), .xm_set_o(xm_set_o));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [19:0] pc; logic [19:0] rd; logic we; logic cyw; logic cy; logic xm; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit fin = 0;
  logic [19:0] mstk [8];
  logic [19:0] last_pc = '0;

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mpop();
    logic [19:0] t = mstk[0];
    for (int i = 0; i < 7; i++) mstk[i] = mstk[i+1];
    mstk[7] = '0;
    return t;
  endfunction

  function automatic void mpush(input logic [19:0] v);
    for (int i = 7; i > 0; i--) mstk[i] = mstk[i-1];
    mstk[0] = v;
  endfunction

  task automatic op(input logic [3:0] k, input logic [19:0] pc, input logic [3:0] ln,
                    input logic [15:0] of, input logic [19:0] tg, input logic cd,
                    input logic [19:0] rg, input string tag);
    exp_t e;
    logic [19:0] sq;
    @(negedge clk); #1;
    valid_i = 1'b1; kind_i = k; pc_i = pc; len_i = ln; ofs_i = of;
    tgt_i = tg; cond_i = cd; reg_i = rg;
    sq = pc + {16'd0, ln};
    e.pc = sq; e.rd = '0; e.we = 0; e.cyw = 0; e.cy = 0; e.xm = 0; e.tag = tag;
    case (k)
      4'd1: if (cd && of[7:0] == 8'd0) e.pc = mpop();
            else if (cd) e.pc = pc + {{12{of[7]}}, of[7:0]};
      4'd2: e.pc = pc + {{8{of[11]}}, of[11:0]};
      4'd3: e.pc = pc + {{4{of[15]}}, of};
      4'd4: begin mpush(sq); e.pc = pc + {{8{of[11]}}, of[11:0]}; end
      4'd5: begin mpush(sq); e.pc = pc + {{4{of[15]}}, of}; end
      4'd6: e.pc = tg;
      4'd7: begin mpush(sq); e.pc = tg; end
      4'd8: e.pc = rg;
      4'd9: begin e.pc = rg; e.we = 1; e.rd = sq; end
      4'd10: e.pc = mpop();
      4'd11: begin e.pc = mpop(); e.cyw = 1; e.cy = 0; end
      4'd12: begin e.pc = mpop(); e.cyw = 1; e.cy = 1; end
      4'd13: begin e.pc = mpop(); e.xm = 1; end
      4'd14: mpush(rg);
      4'd15: begin e.we = 1; e.rd = mpop(); end
      default: ;
    endcase
    last_pc = e.pc;
    q.push_back(e);
  endtask

  task automatic idle(input logic [3:0] k, input string tag);
    exp_t e;
    @(negedge clk); #1;
    valid_i = 1'b0; kind_i = k; reg_i = 20'hABCDE; pc_i = 20'h11111;
    e.pc = last_pc; e.rd = '0; e.we = 0; e.cyw = 0; e.cy = 0; e.xm = 0; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " pc"}, pc_o, e.pc);
      chk({e.tag, " rdat_we"}, {19'd0, rdat_we_o}, {19'd0, e.we});
      if (e.we) chk({e.tag, " rdat"}, rdat_o, e.rd);
      chk({e.tag, " cy_we"}, {19'd0, cy_we_o}, {19'd0, e.cyw});
      if (e.cyw) chk({e.tag, " cy"}, {19'd0, cy_o}, {19'd0, e.cy});
      chk({e.tag, " xm"}, {19'd0, xm_set_o}, {19'd0, e.xm});
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mstk[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc_o, 20'h0);
    chk("R1 pulses", {17'd0, rdat_we_o, cy_we_o, xm_set_o}, 20'h0);
    rst_n = 1'b1;
    op(4'd15, 20'h00100, 4'd2, 16'h0, 20'h0, 0, 20'h0, "R1 R13 empty pop");
    op(4'd0, 20'h00200, 4'd4, 16'h0, 20'h0, 0, 20'h0, "R2 seq");
    op(4'd1, 20'h00300, 4'd3, 16'h0010, 20'h0, 0, 20'h0, "R2 not taken");
    op(4'd1, 20'h00400, 4'd3, 16'hFF7F, 20'h0, 1, 20'h0, "R3 +127");
    op(4'd1, 20'h00050, 4'd3, 16'h0080, 20'h0, 1, 20'h0, "R3 -128 wrap");
    op(4'd2, 20'h10000, 4'd4, 16'h0800, 20'h0, 0, 20'h0, "R5 -2048");
    op(4'd2, 20'h10000, 4'd4, 16'hF7FF, 20'h0, 0, 20'h0, "R5 +2047");
    op(4'd3, 20'h10000, 4'd5, 16'h8000, 20'h0, 0, 20'h0, "R5 -32768");
    op(4'd3, 20'h10000, 4'd5, 16'h7FFF, 20'h0, 0, 20'h0, "R5 +32767");
    op(4'd6, 20'h10000, 4'd7, 16'h0, 20'hC0DE5, 0, 20'h0, "R7 jump abs");
    op(4'd4, 20'h20000, 4'd4, 16'h0100, 20'h0, 0, 20'h0, "R6 call short");
    op(4'd10, 20'h20100, 4'd2, 16'h0, 20'h0, 0, 20'h0, "R8 return");
    op(4'd7, 20'h30000, 4'd7, 16'h0, 20'h45678, 0, 20'h0, "R6 call abs");
    op(4'd11, 20'h45678, 4'd2, 16'h0, 20'h0, 0, 20'h0, "R9 return clear carry");
    op(4'd5, 20'h40000, 4'd6, 16'h9000, 20'h0, 0, 20'h0, "R6 call long");
    op(4'd12, 20'h31000, 4'd2, 16'h0, 20'h0, 0, 20'h0, "R9 return set carry");
    op(4'd14, 20'h50000, 4'd2, 16'h0, 20'h0, 0, 20'h7A7A7, "R12 push");
    op(4'd13, 20'h50002, 4'd3, 16'h0, 20'h0, 0, 20'h0, "R10 return set flag");
    op(4'd4, 20'h60000, 4'd4, 16'h0020, 20'h0, 0, 20'h0, "R6 call before cond ret");
    op(4'd1, 20'h60020, 4'd3, 16'h1200, 20'h0, 0, 20'h0, "R4 zero ofs not taken");
    op(4'd1, 20'h60023, 4'd3, 16'h1200, 20'h0, 1, 20'h0, "R4 zero ofs taken");
    op(4'd8, 20'h60004, 4'd3, 16'h0, 20'h0, 0, 20'h12345, "R11 reg jump");
    op(4'd9, 20'h12345, 4'd3, 16'h0, 20'h0, 0, 20'h54321, "R11 exchange");
    for (int i = 0; i < 9; i++)
      op(4'd14, 20'h70000, 4'd2, 16'h0, 20'h0, 0, 20'h00A00 + 20'(i), "R13 push full");
    for (int i = 0; i < 9; i++)
      op(4'd15, 20'h71000, 4'd2, 16'h0, 20'h0, 0, 20'h0, "R13 pop after overflow");
    idle(4'd14, "R14 idle push");
    idle(4'd12, "R14 idle ret");
    op(4'd15, 20'h72000, 4'd2, 16'h0, 20'h0, 0, 20'h0, "R14 stack untouched");
    op(4'd10, 20'h72000, 4'd2, 16'h0, 20'h0, 0, 20'h0, "R13 return empty");
    @(negedge clk); #1; valid_i = 1'b0;
    repeat (3) @(negedge clk);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule